// File: doc/BRIEF.md
# Two-Clock Interlocked Request/Acknowledge Bus Link

This block joins an initiating side and a responding side over a bus that has no shared clock. Each side runs on its own local clock. The initiator takes a read or write command from a simple local port (start, direction, address, write data). It then completes the transfer with the responder through an interlocked sequence on level-sensitive control wires. Every control level that crosses from one side to the other passes through a two-stage synchronizer before the receiving side acts on it.

The responder has a register-file style memory port. It latches the address, and the write data if there is any. It performs the access and reports completion on its data-ready line. For reads it waits a programmable number of local cycles before it fetches the word. The initiator raises `done` for one cycle once every control wire has returned low. Any `start` that arrives while a transfer is in flight is ignored.

Top module: `hsbus_link`

## Requirements
- R1: While either reset is asserted, all five bus control outputs, `done`, `mem_rd` and `mem_wr` are low, and `rdata` is zero.
- R2: On `start` the initiator raises exactly one request line: `bus_wr_req` when `rw`=1, `bus_rd_req` when `rw`=0. The address and write data it drives stay stable while the request is high.
- R3: The responder raises `bus_s_ack` only after it sees a request. The initiator drops its request only after it sees that acknowledge. The responder drops `bus_s_ack` only after the request is low.
- R4: On a read, the responder raises `bus_drdy` only while `bus_s_ack` is low. `rdata` then equals the word stored at the requested address.
- R5: Counted in falling edges of `clk_s`, `bus_drdy` rises exactly `lat`+2 responder cycles after `bus_s_ack` falls on a read. On a write it rises exactly 2 cycles after, whatever `lat` holds.
- R6: A write produces exactly one `mem_wr` pulse, which stores `wdata` at `addr`. `mem_rd` and `mem_wr` are never high together.
- R7: The initiator raises `bus_m_ack` only after it sees `bus_drdy`. The responder drops `bus_drdy` only after it sees `bus_m_ack`. The initiator drops `bus_m_ack` only after `bus_drdy` is low. Taken as the vector {request, s_ack, drdy, m_ack}, the control wires step through 1000, 1100, 0100, 0000, 0010, 0011, 0001, 0000.
- R8: `done` is high for exactly one `clk_m` cycle per transfer, and all bus control lines are low in that cycle.
- R9: A `start` that arrives while a transfer is in flight causes no second transfer, no memory write and no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Initiator local clock |
| rst_m_n | input | 1 | Initiator asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| rw | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Transfer address |
| wdata | input | DW | Write data |
| rdata | output | DW | Data returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| clk_s | input | 1 | Responder local clock |
| rst_s_n | input | 1 | Responder asynchronous active-low reset |
| lat | input | LW | Extra responder cycles before a read fetch |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (combinational) |
| bus_rd_req | output | 1 | Read request wire |
| bus_wr_req | output | 1 | Write request wire |
| bus_s_ack | output | 1 | Responder acknowledge wire |
| bus_m_ack | output | 1 | Initiator acknowledge wire |
| bus_drdy | output | 1 | Data-ready wire |

## Verification
The hardest case to reach from the ports is a second `start` that lands in the middle of the interlock, while the responder still holds its acknowledge. The stimulus pulses `start` a few initiator cycles after the first command, with a different address and data. It then lets the link idle long enough for any stray transfer to show up as a memory write or a second `done`. Latency is measured across the clock boundary by timestamping the acknowledge fall and the data-ready rise against a responder-cycle count taken on the opposite clock edge. The two clock periods are deliberately unrelated.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_REQ, M_DROP, M_WDR, M_TAKE
  } mst_st_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ACK, S_LAT, S_RD, S_WR, S_DRDY, S_END
  } slv_st_t;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/hsb_master.sv
module hsb_master
  import hsb_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          bus_rd_req,
  output logic          bus_wr_req,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_m_ack,
  input  logic          s_ack_in,
  input  logic          drdy_in,
  input  logic [DW-1:0] bus_rdata
);
  logic [1:0] sq;
  logic ack_s, drdy_s;

  hsb_sync #(.W(2)) u_sync (.clk(clk), .rst_n(rst_n), .d({s_ack_in, drdy_in}), .q(sq));
  assign ack_s  = sq[1];
  assign drdy_s = sq[0];

  mst_st_t st_q, st_d;
  logic rd_q, rd_d, wr_q, wr_d, mack_q, mack_d, done_q, done_d, isw_q, isw_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d, rdata_q, rdata_d;

  always_comb begin
    st_d = st_q; rd_d = rd_q; wr_d = wr_q; mack_d = mack_q; done_d = 1'b0;
    isw_d = isw_q; addr_d = addr_q; wdata_d = wdata_q; rdata_d = rdata_q;
    case (st_q)
      M_IDLE: if (start) begin
        addr_d = addr; wdata_d = wdata; isw_d = rw;
        rd_d = !rw; wr_d = rw; st_d = M_REQ;
      end
      M_REQ: if (ack_s) begin
        rd_d = 1'b0; wr_d = 1'b0; st_d = M_DROP;
      end
      M_DROP: if (!ack_s) st_d = M_WDR;
      M_WDR: if (drdy_s) begin
        mack_d = 1'b1;
        if (!isw_q) rdata_d = bus_rdata;
        st_d = M_TAKE;
      end
      M_TAKE: if (!drdy_s) begin
        mack_d = 1'b0; done_d = 1'b1; st_d = M_IDLE;
      end
      default: st_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= M_IDLE; rd_q <= 1'b0; wr_q <= 1'b0; mack_q <= 1'b0; done_q <= 1'b0;
      isw_q <= 1'b0; addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
    end else begin
      st_q <= st_d; rd_q <= rd_d; wr_q <= wr_d; mack_q <= mack_d; done_q <= done_d;
      isw_q <= isw_d; addr_q <= addr_d; wdata_q <= wdata_d; rdata_q <= rdata_d;
    end
  end

  assign bus_rd_req = rd_q;
  assign bus_wr_req = wr_q;
  assign bus_addr   = addr_q;
  assign bus_wdata  = wdata_q;
  assign bus_m_ack  = mack_q;
  assign rdata      = rdata_q;
  assign done       = done_q;

  // R2
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rd_q && wr_q));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_q || wr_q) && $past(rd_q || wr_q)) |-> ($stable(addr_q) && $stable(wdata_q)));
  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_q || wr_q) |-> $past(ack_s));
  // R7
  mack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mack_q) |-> $past(drdy_s));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/hsb_slave.sv
module hsb_slave
  import hsb_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lat,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          rd_req_in,
  input  logic          wr_req_in,
  input  logic          m_ack_in,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_s_ack,
  output logic          bus_drdy,
  output logic [DW-1:0] bus_rdata
);
  logic [2:0] sq;
  logic rd_s, wr_s, mack_s, req_s;

  hsb_sync #(.W(3)) u_sync (.clk(clk), .rst_n(rst_n),
    .d({rd_req_in, wr_req_in, m_ack_in}), .q(sq));
  assign rd_s   = sq[2];
  assign wr_s   = sq[1];
  assign mack_s = sq[0];
  assign req_s  = rd_s | wr_s;

  slv_st_t st_q, st_d;
  logic ack_q, ack_d, drdy_q, drdy_d, isw_q, isw_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d = st_q; ack_d = ack_q; drdy_d = drdy_q; isw_d = isw_q;
    addr_d = addr_q; wdata_d = wdata_q; rdata_d = rdata_q; cnt_d = cnt_q;
    case (st_q)
      S_IDLE: if (req_s) begin
        addr_d = bus_addr; wdata_d = bus_wdata; isw_d = wr_s;
        ack_d = 1'b1; st_d = S_ACK;
      end
      S_ACK: if (!req_s) begin
        ack_d = 1'b0; cnt_d = '0; st_d = S_LAT;
      end
      S_LAT: begin
        if (isw_q)              st_d = S_WR;
        else if (cnt_q == lat)  st_d = S_RD;
        else                    cnt_d = cnt_q + 1'b1;
      end
      S_WR: begin
        drdy_d = 1'b1; st_d = S_DRDY;
      end
      S_RD: begin
        rdata_d = mem_rdata; drdy_d = 1'b1; st_d = S_DRDY;
      end
      S_DRDY: if (mack_s) begin
        drdy_d = 1'b0; st_d = S_END;
      end
      S_END: if (!mack_s) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ack_q <= 1'b0; drdy_q <= 1'b0; isw_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0; rdata_q <= '0; cnt_q <= '0;
    end else begin
      st_q <= st_d; ack_q <= ack_d; drdy_q <= drdy_d; isw_q <= isw_d;
      addr_q <= addr_d; wdata_q <= wdata_d; rdata_q <= rdata_d; cnt_q <= cnt_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_wr    = (st_q == S_WR);
  assign mem_rd    = (st_q == S_RD);
  assign bus_s_ack = ack_q;
  assign bus_drdy  = drdy_q;
  assign bus_rdata = rdata_q;

  // R3
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_s));
  // R3
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> $past(!req_s));
  // R4
  drdy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_q) |-> !ack_q);
  // R7
  drdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_q) |-> $past(mack_s));
  // R6
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: rtl/hsbus_link.sv
module hsbus_link #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk_m,
  input  logic          rst_m_n,
  input  logic          start,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  input  logic          clk_s,
  input  logic          rst_s_n,
  input  logic [LW-1:0] lat,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_rd_req,
  output logic          bus_wr_req,
  output logic          bus_s_ack,
  output logic          bus_m_ack,
  output logic          bus_drdy
);
  logic rst_m_sync, rst_s_sync;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_wdata, b_rdata;
  logic rd_w, wr_w, sack_w, mack_w, drdy_w;

  hsb_sync #(.W(1)) u_rsm (.clk(clk_m), .rst_n(rst_m_n), .d(1'b1), .q(rst_m_sync));
  hsb_sync #(.W(1)) u_rss (.clk(clk_s), .rst_n(rst_s_n), .d(1'b1), .q(rst_s_sync));

  hsb_master #(.AW(AW), .DW(DW)) u_mst (
    .clk(clk_m), .rst_n(rst_m_sync), .start(start), .rw(rw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done), .bus_rd_req(rd_w),
    .bus_wr_req(wr_w), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_m_ack(mack_w), .s_ack_in(sack_w), .drdy_in(drdy_w), .bus_rdata(b_rdata)
  );

  hsb_slave #(.AW(AW), .DW(DW), .LW(LW)) u_slv (
    .clk(clk_s), .rst_n(rst_s_sync), .lat(lat), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rd_req_in(rd_w), .wr_req_in(wr_w), .m_ack_in(mack_w), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_s_ack(sack_w), .bus_drdy(drdy_w), .bus_rdata(b_rdata)
  );

  assign bus_rd_req = rd_w;
  assign bus_wr_req = wr_w;
  assign bus_s_ack  = sack_w;
  assign bus_m_ack  = mack_w;
  assign bus_drdy   = drdy_w;
endmodule

// File: tb/hsbus_link_tb.sv
`timescale 1ns/1ps
module hsbus_link_tb;
  logic clk_m = 1'b0, clk_s = 1'b0, rst_m_n = 1'b0, rst_s_n = 1'b0;
  logic start = 1'b0, rw = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [2:0] lat = '0;
  logic [7:0] rdata, mem_wdata, mem_rdata;
  logic [3:0] mem_addr;
  logic done, mem_rd, mem_wr, rdq, wrq, sack, mack, drdy;

  always #10 clk_m = ~clk_m;
  always #13.5 clk_s = ~clk_s;

  hsbus_link #(.AW(4), .DW(8), .LW(3)) u_dut (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .start(start), .rw(rw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .lat(lat), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .bus_rd_req(rdq),
    .bus_wr_req(wrq), .bus_s_ack(sack), .bus_m_ack(mack), .bus_drdy(drdy)
  );

  int checks = 0, errors = 0;
  logic [7:0] mem [16];
  logic [7:0] shadow [16];
  int wr_cnt = 0;
  int scnt = 0, t_fall = 0, meas = -1;
  bit mon_en = 1'b0;
  int step = 0;
  logic [3:0] ctl;
  logic [3:0] seq [8];

  assign mem_rdata = mem[mem_addr];
  assign ctl = {rdq | wrq, sack, drdy, mack};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk_s) if (mem_wr) begin
    mem[mem_addr] <= mem_wdata;
    wr_cnt <= wr_cnt + 1;
  end

  always @(negedge clk_s) scnt++;
  always @(negedge sack) if (mon_en) t_fall = scnt;
  always @(posedge drdy) if (mon_en) meas = scnt - t_fall;

  // R3 R7: every control change must follow the interlocked order
  always @(ctl) if (mon_en) begin
    chk(ctl == seq[(step + 1) % 8], "R3/R7 order", {28'd0, ctl}, {28'd0, seq[(step + 1) % 8]});
    step = (step + 1) % 8;
  end

  // rw, addr, wdata, lat
  localparam logic [15:0] VEC [10] = '{
    {1'b1, 4'h1, 8'hA5, 3'd0},
    {1'b1, 4'h2, 8'h3C, 3'd5},
    {1'b0, 4'h1, 8'h00, 3'd0},
    {1'b0, 4'h2, 8'h00, 3'd3},
    {1'b1, 4'hF, 8'hFF, 3'd7},
    {1'b0, 4'hF, 8'h00, 3'd7},
    {1'b0, 4'h7, 8'h00, 3'd1},
    {1'b1, 4'h0, 8'h00, 3'd2},
    {1'b0, 4'h0, 8'h00, 3'd6},
    {1'b0, 4'h9, 8'h00, 3'd4}
  };

  task automatic run(input bit w, input logic [3:0] a, input logic [7:0] d, input logic [2:0] l);
    int n;
    int wc0;
    lat = l;
    wc0 = wr_cnt;
    @(negedge clk_m);
    start = 1'b1; rw = w; addr = a; wdata = d;
    @(negedge clk_m);
    start = 1'b0;
    chk(w ? (wrq && !rdq) : (rdq && !wrq), "R2 request line", {30'd0, rdq, wrq}, w ? 32'd1 : 32'd2);
    n = 0;
    while (!done && n < 3000) begin @(negedge clk_m); n++; end
    chk(n < 3000, "R8 done seen", n, 3000);
    chk(ctl == 4'b0000, "R8 lines low at done", {28'd0, ctl}, 0);
    @(negedge clk_m);
    chk(!done, "R8 one-cycle done", {31'd0, done}, 0);
    if (w) begin
      chk(mem[a] == d, "R6 stored word", mem[a], d);
      chk(wr_cnt == wc0 + 1, "R6 single write", wr_cnt, wc0 + 1);
      chk(meas == 2, "R5 write drdy delay", meas, 2);
      shadow[a] = d;
    end else begin
      chk(rdata == shadow[a], "R4 read data", rdata, shadow[a]);
      chk(meas == l + 2, "R5 read drdy delay", meas, l + 2);
    end
  endtask

  initial begin
    #3800000;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seq = '{4'b0000, 4'b1000, 4'b1100, 4'b0100, 4'b0000, 4'b0010, 4'b0011, 4'b0001};
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'(i * 17 + 3);
      shadow[i] = 8'(i * 17 + 3);
    end
    repeat (5) @(negedge clk_s);
    // R1 reset state
    chk(ctl == 4'b0000 && !rdq && !wrq, "R1 bus lines", {28'd0, ctl}, 0);
    chk(!done && !mem_wr && !mem_rd, "R1 done/strobes", {29'd0, done, mem_wr, mem_rd}, 0);
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    rst_m_n = 1'b1; rst_s_n = 1'b1;
    repeat (6) @(negedge clk_s);
    mon_en = 1'b1;

    for (int v = 0; v < 10; v++)
      run(VEC[v][15], VEC[v][14:11], VEC[v][10:3], VEC[v][2:0]);

    // R9 start while busy is ignored
    begin
      int wc0;
      int n;
      int dn;
      wc0 = wr_cnt; lat = 3'd2;
      @(negedge clk_m);
      start = 1'b1; rw = 1'b1; addr = 4'h3; wdata = 8'h77;
      @(negedge clk_m); start = 1'b0;
      repeat (4) @(negedge clk_m);
      start = 1'b1; rw = 1'b1; addr = 4'h5; wdata = 8'hEE;
      @(negedge clk_m); start = 1'b0;
      n = 0;
      while (!done && n < 3000) begin @(negedge clk_m); n++; end
      chk(n < 3000, "R9 first done", n, 3000);
      shadow[3] = 8'h77;
      dn = 0;
      repeat (200) begin @(negedge clk_m); if (done) dn++; end
      chk(dn == 0, "R9 no second done", dn, 0);
      chk(wr_cnt == wc0 + 1, "R9 single write", wr_cnt, wc0 + 1);
      chk(mem[5] == shadow[5], "R9 addr 5 untouched", mem[5], shadow[5]);
      chk(mem[3] == 8'h77, "R6 busy-case write", mem[3], 8'h77);
      chk(ctl == 4'b0000, "R9 bus idle", {28'd0, ctl}, 0);
    end

    run(1'b0, 4'h5, 8'h00, 3'd0);
    run(1'b0, 4'h3, 8'h00, 3'd7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule